// File: doc/BRIEF.md
# Instruction Word Byte Gating Unit

This block is a small store for 32-bit instruction words. Each word is split into four 8-bit lanes, and every lane is read only when it carries information. The two upper lanes (bits 31:24 and 23:16) each get a zero flag, set when the fill writes all-zero bits into that lane. Whether a lower lane (bits 15:8 and 7:0) is read depends on the 2-bit length code that arrives with the instruction, not on the lane's value.

On a fetch, a lane that is flagged zero or unused by the length is not taken from the store. It comes back as 0x00. The fetched word and its stored length code appear one cycle after the request.

Two counters record how many upper-lane reads and how many lower-lane reads were suppressed. This lets the saving from gating be measured on a real instruction stream. `DEPTH` must be a power of two.

Top module: `instr_byte_gate`

## Requirements
- R1: After reset `fetch_vld` is 0, `fetch_instr` is 0 and both counters are 0. Every entry that has not been filled reads back as word 0 with length code 2'b00.
- R2: A fetch requested with `fetch_en` high at a clock edge sets `fetch_vld` high with its data after that edge. With no request, `fetch_vld` is low after the edge.
- R3: Length code 2'b00 (short) uses only bits 31:16. Code 2'b01 (medium) also uses bits 15:8. Codes 2'b10 and 2'b11 (long) use all 32 bits. A lower lane that the length does not use returns 0x00.
- R4: An upper lane (31:24 or 23:16) that was nonzero at fill returns its filled value. One that was zero returns 0x00. A lower lane that the length uses returns its filled value exactly, even when that value is zero.
- R5: `fetch_len` presents the 2-bit length code exactly as it was filled, including 2'b11.
- R6: Each fetch adds the number of zero-flagged upper lanes (0 to 2) to `upper_gated_cnt`. The counter wraps modulo 2^CNT_W.
- R7: Each fetch adds the number of unused lower lanes to `lower_gated_cnt`: 2 for short, 1 for medium, 0 for long. The counter wraps. Both counters hold when there is no fetch.
- R8: A fill and a fetch to the same address in the same cycle return the entry's previous contents. The new contents are returned by later fetches.
- R9: A fill changes only the addressed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_en | input | 1 | Write one instruction word |
| fill_addr | input | $clog2(DEPTH) | Entry to write |
| fill_instr | input | 4*BYTE_W | Instruction word to store |
| fill_len | input | 2 | Length code: 00 short, 01 medium, 10/11 long |
| fetch_en | input | 1 | Read request |
| fetch_addr | input | $clog2(DEPTH) | Entry to read |
| fetch_vld | output | 1 | Fetched data valid, one cycle after the request |
| fetch_instr | output | 4*BYTE_W | Fetched word with gated lanes at zero |
| fetch_len | output | 2 | Stored length code of the fetched word |
| upper_gated_cnt | output | CNT_W | Running count of suppressed upper-lane reads |
| lower_gated_cnt | output | CNT_W | Running count of suppressed lower-lane reads |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Zero lower lane under long length.** A design that zero-detects the lower lanes would still return the right bits for such a word. Its lower counter, however, would move when it should not.
- **Code 2'b11.** A design that treats this code as short or medium would clear bits that must survive.
- **Fill and fetch to one address in one cycle.** A store with write-through reads would return the new word a cycle early.
- **Unfilled entries.** An entry reset without its zero flags would leave the upper counter unchanged when it should move.
- **Counter wrap.** The bench uses a narrow counter width and fetches enough short words for both counters to wrap. It checks the wrapped values.

// File: rtl/ibg_pkg.sv
package ibg_pkg;

    typedef enum logic [1:0] {
        LEN_SHORT    = 2'b00,
        LEN_MEDIUM   = 2'b01,
        LEN_LONG     = 2'b10,
        LEN_LONG_ALT = 2'b11
    } len_code_e;

    // bit 1: lane 1 (bits 15:8) in use, bit 0: lane 0 (bits 7:0) in use
    function automatic logic [1:0] lower_lanes_used(input logic [1:0] code);
        logic [1:0] used;
        case (len_code_e'(code))
            LEN_SHORT:  used = 2'b00;
            LEN_MEDIUM: used = 2'b10;
            default:    used = 2'b11;
        endcase
        return used;
    endfunction

    function automatic logic [1:0] count_two(input logic [1:0] v);
        return 2'(v[1]) + 2'(v[0]);
    endfunction

endpackage

// File: rtl/ibg_fill_encode.sv
module ibg_fill_encode #(
    parameter int unsigned BYTE_W  = 8,
    localparam int unsigned INSTR_W = 4 * BYTE_W
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [1:0]         len,
    output logic [INSTR_W-1:0] store_word,
    output logic [1:0]         zero_flags
);
    import ibg_pkg::*;

    logic [1:0] lo_used;
    assign lo_used = lower_lanes_used(len);

    // upper lanes: flag zero bytes, store nothing for them
    for (genvar g = 0; g < 2; g++) begin : g_upper
        localparam int unsigned LSB = (g + 2) * BYTE_W;
        assign zero_flags[g] = (instr[LSB +: BYTE_W] == '0);
        assign store_word[LSB +: BYTE_W] = zero_flags[g] ? '0 : instr[LSB +: BYTE_W];
    end

    // lower lanes: write only the lanes the length uses
    for (genvar g = 0; g < 2; g++) begin : g_lower
        localparam int unsigned LSB = g * BYTE_W;
        assign store_word[LSB +: BYTE_W] = lo_used[g] ? instr[LSB +: BYTE_W] : '0;
    end

endmodule

// File: rtl/ibg_word_store.sv
module ibg_word_store #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned INSTR_W = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [INSTR_W-1:0] wr_word,
    input  logic [1:0]         wr_zero,
    input  logic [1:0]         wr_len,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [INSTR_W-1:0] rd_word,
    output logic [1:0]         rd_zero,
    output logic [1:0]         rd_len
);
    typedef struct packed {
        logic [INSTR_W-1:0] word;
        logic [1:0]         zero;
        logic [1:0]         len;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
    } store_t;

    localparam entry_t EMPTY_ENTRY = '{word: '0, zero: 2'b11, len: 2'b00};

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[wr_addr] = '{word: wr_word, zero: wr_zero, len: wr_len};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.mem[i] <= EMPTY_ENTRY;
            end
        end else begin
            st_q <= st_d;
        end
    end

    // read from registered state: a same-cycle fill is not visible yet
    assign rd_word = st_q.mem[rd_addr].word;
    assign rd_zero = st_q.mem[rd_addr].zero;
    assign rd_len  = st_q.mem[rd_addr].len;

endmodule

// File: rtl/ibg_fetch_gate.sv
module ibg_fetch_gate #(
    parameter int unsigned BYTE_W  = 8,
    localparam int unsigned INSTR_W = 4 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_en,
    input  logic [INSTR_W-1:0] rd_word,
    input  logic [1:0]         rd_zero,
    input  logic [1:0]         rd_len,
    output logic               out_vld,
    output logic [INSTR_W-1:0] out_word,
    output logic [1:0]         out_len,
    output logic [1:0]         upper_skip,
    output logic [1:0]         lower_skip
);
    import ibg_pkg::*;

    typedef struct packed {
        logic               vld;
        logic [INSTR_W-1:0] word;
        logic [1:0]         len;
    } out_t;

    out_t o_d, o_q;
    logic [INSTR_W-1:0] gated;
    logic [1:0]         lo_used;

    assign lo_used = lower_lanes_used(rd_len);

    for (genvar g = 0; g < 2; g++) begin : g_upper
        localparam int unsigned LSB = (g + 2) * BYTE_W;
        assign gated[LSB +: BYTE_W] = rd_zero[g] ? '0 : rd_word[LSB +: BYTE_W];
    end

    for (genvar g = 0; g < 2; g++) begin : g_lower
        localparam int unsigned LSB = g * BYTE_W;
        assign gated[LSB +: BYTE_W] = lo_used[g] ? rd_word[LSB +: BYTE_W] : '0;
    end

    assign upper_skip = count_two(rd_zero);
    assign lower_skip = count_two(~lo_used);

    always_comb begin
        o_d     = o_q;
        o_d.vld = fetch_en;
        if (fetch_en) begin
            o_d.word = gated;
            o_d.len  = rd_len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_vld  = o_q.vld;
    assign out_word = o_q.word;
    assign out_len  = o_q.len;

endmodule

// File: rtl/ibg_gate_counters.sv
module ibg_gate_counters #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_en,
    input  logic [1:0]       upper_inc,
    input  logic [1:0]       lower_inc,
    output logic [CNT_W-1:0] upper_cnt,
    output logic [CNT_W-1:0] lower_cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] up;
        logic [CNT_W-1:0] lo;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (fetch_en) begin
            c_d.up = c_q.up + CNT_W'(upper_inc);
            c_d.lo = c_q.lo + CNT_W'(lower_inc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign upper_cnt = c_q.up;
    assign lower_cnt = c_q.lo;

endmodule

// File: rtl/instr_byte_gate.sv
module instr_byte_gate #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned ADDR_W  = $clog2(DEPTH),
    localparam int unsigned INSTR_W = 4 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic [INSTR_W-1:0] fill_instr,
    input  logic [1:0]         fill_len,
    input  logic               fetch_en,
    input  logic [ADDR_W-1:0]  fetch_addr,
    output logic               fetch_vld,
    output logic [INSTR_W-1:0] fetch_instr,
    output logic [1:0]         fetch_len,
    output logic [CNT_W-1:0]   upper_gated_cnt,
    output logic [CNT_W-1:0]   lower_gated_cnt
);
    logic [INSTR_W-1:0] enc_word;
    logic [1:0]         enc_zero;
    logic [INSTR_W-1:0] rd_word;
    logic [1:0]         rd_zero;
    logic [1:0]         rd_len;
    logic [1:0]         upper_skip;
    logic [1:0]         lower_skip;

    ibg_fill_encode #(.BYTE_W(BYTE_W)) u_encode (
        .instr      (fill_instr),
        .len        (fill_len),
        .store_word (enc_word),
        .zero_flags (enc_zero)
    );

    ibg_word_store #(.DEPTH(DEPTH), .INSTR_W(INSTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_en),
        .wr_addr (fill_addr),
        .wr_word (enc_word),
        .wr_zero (enc_zero),
        .wr_len  (fill_len),
        .rd_addr (fetch_addr),
        .rd_word (rd_word),
        .rd_zero (rd_zero),
        .rd_len  (rd_len)
    );

    ibg_fetch_gate #(.BYTE_W(BYTE_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (fetch_en),
        .rd_word    (rd_word),
        .rd_zero    (rd_zero),
        .rd_len     (rd_len),
        .out_vld    (fetch_vld),
        .out_word   (fetch_instr),
        .out_len    (fetch_len),
        .upper_skip (upper_skip),
        .lower_skip (lower_skip)
    );

    ibg_gate_counters #(.CNT_W(CNT_W)) u_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_en  (fetch_en),
        .upper_inc (upper_skip),
        .lower_inc (lower_skip),
        .upper_cnt (upper_gated_cnt),
        .lower_cnt (lower_gated_cnt)
    );

endmodule

// File: rtl/instr_byte_gate_chk.sv
module instr_byte_gate_chk #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned INSTR_W = 4 * BYTE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_vld,
    input logic [INSTR_W-1:0] fetch_instr,
    input logic [1:0]         fetch_len,
    input logic [CNT_W-1:0]   upper_gated_cnt,
    input logic [CNT_W-1:0]   lower_gated_cnt
);
    logic [1:0] zero_upper;
    logic [1:0] unused_lower;

    assign zero_upper = 2'(fetch_instr[3*BYTE_W +: BYTE_W] == '0)
                      + 2'(fetch_instr[2*BYTE_W +: BYTE_W] == '0);
    assign unused_lower = (fetch_len == 2'b00) ? 2'd2 :
                          (fetch_len == 2'b01) ? 2'd1 : 2'd0;

    AST_SHORT_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_len == 2'b00) |-> (fetch_instr[2*BYTE_W-1:0] == '0)) else $error("short word leaks lower lanes"); // R3

    AST_MEDIUM_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fetch_len == 2'b01) |-> (fetch_instr[BYTE_W-1:0] == '0)) else $error("medium word leaks lane 0"); // R3

    AST_UPPER_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |-> ((upper_gated_cnt - $past(upper_gated_cnt)) == CNT_W'(zero_upper))) else $error("upper count step wrong"); // R6

    AST_LOWER_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |-> ((lower_gated_cnt - $past(lower_gated_cnt)) == CNT_W'(unused_lower))) else $error("lower count step wrong"); // R7

    AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |-> ($stable(upper_gated_cnt) && $stable(lower_gated_cnt))) else $error("counter moved without fetch"); // R7

endmodule

bind instr_byte_gate instr_byte_gate_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_vld       (fetch_vld),
    .fetch_instr     (fetch_instr),
    .fetch_len       (fetch_len),
    .upper_gated_cnt (upper_gated_cnt),
    .lower_gated_cnt (lower_gated_cnt)
);

// File: tb/instr_byte_gate_bench.sv
module instr_byte_gate_bench;
    localparam int DEPTH  = 16;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 6;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int W      = 4 * BYTE_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              fill_en;
    logic [ADDR_W-1:0] fill_addr;
    logic [W-1:0]      fill_instr;
    logic [1:0]        fill_len;
    logic              fetch_en;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_vld;
    logic [W-1:0]      fetch_instr;
    logic [1:0]        fetch_len;
    logic [CNT_W-1:0]  upper_gated_cnt;
    logic [CNT_W-1:0]  lower_gated_cnt;

    instr_byte_gate #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_instr_byte_gate (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_instr(fill_instr), .fill_len(fill_len),
        .fetch_en(fetch_en), .fetch_addr(fetch_addr),
        .fetch_vld(fetch_vld), .fetch_instr(fetch_instr), .fetch_len(fetch_len),
        .upper_gated_cnt(upper_gated_cnt), .lower_gated_cnt(lower_gated_cnt)
    );

    typedef struct packed {
        logic [W-1:0] word;
        logic [1:0]   len;
        logic [1:0]   up;
        logic [1:0]   lo;
    } exp_t;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [W-1:0]     m_word [DEPTH];
    logic [1:0]       m_len  [DEPTH];
    exp_t             exp_q[$];
    string            tag_q[$];
    logic [CNT_W-1:0] exp_up = '0;
    logic [CNT_W-1:0] exp_lo = '0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected result from the requirements: R3 length gating, R4 upper zero flags
    function automatic exp_t predict(input logic [W-1:0] w, input logic [1:0] len);
        exp_t e;
        e.word = w;
        e.len  = len;
        e.up   = 2'd0;
        e.lo   = 2'd0;
        if (w[3*BYTE_W +: BYTE_W] == '0) e.up = e.up + 2'd1;
        if (w[2*BYTE_W +: BYTE_W] == '0) e.up = e.up + 2'd1;
        if (len == 2'b00) begin
            e.word[2*BYTE_W-1:0] = '0;
            e.lo = 2'd2;
        end else if (len == 2'b01) begin
            e.word[BYTE_W-1:0] = '0;
            e.lo = 2'd1;
        end
        return e;
    endfunction

    // driver: one cycle of optional fill and optional fetch
    task automatic step(input bit f_do, input int fa, input logic [W-1:0] fw, input logic [1:0] fl,
                        input bit r_do, input int ra, input string tag);
        @(negedge clk);
        fill_en    = f_do;
        fill_addr  = ADDR_W'(fa);
        fill_instr = fw;
        fill_len   = fl;
        fetch_en   = r_do;
        fetch_addr = ADDR_W'(ra);
        if (r_do) begin
            exp_q.push_back(predict(m_word[ra], m_len[ra]));
            tag_q.push_back(tag);
        end
        if (f_do) begin
            m_word[fa] = fw;
            m_len[fa]  = fl;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, '0, 2'b00, 1'b0, 0, "");
    endtask

    task automatic fill(input int fa, input logic [W-1:0] fw, input logic [1:0] fl);
        step(1'b1, fa, fw, fl, 1'b0, 0, "");
    endtask

    task automatic fetch(input int ra, input string tag);
        step(1'b0, 0, '0, 2'b00, 1'b1, ra, tag);
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n && fetch_vld) begin
            if (exp_q.size() == 0) begin
                check("R2 valid without request", W'(fetch_vld), W'(0));
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                exp_up = exp_up + CNT_W'(e.up);
                exp_lo = exp_lo + CNT_W'(e.lo);
                check(t, fetch_instr, e.word);
                check("R5 length code", W'(fetch_len), W'(e.len));
                check("R6 upper count", W'(upper_gated_cnt), W'(exp_up));
                check("R7 lower count", W'(lower_gated_cnt), W'(exp_lo));
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < DEPTH; i++) begin
            m_word[i] = '0;
            m_len[i]  = 2'b00;
        end
        rst_n = 1'b0;
        fill_en = 1'b0; fill_addr = '0; fill_instr = '0; fill_len = '0;
        fetch_en = 1'b0; fetch_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", W'(fetch_vld), W'(0));
        check("R1 reset word", fetch_instr, W'(0));
        check("R1 reset upper count", W'(upper_gated_cnt), W'(0));
        check("R1 reset lower count", W'(lower_gated_cnt), W'(0));

        fetch(5, "R1 unfilled entry");

        fill(0, 32'h1234_5678, 2'b10);
        fill(1, 32'h00AB_CDEF, 2'b01);
        fill(2, 32'h0000_1234, 2'b00);
        fill(3, 32'h3400_0000, 2'b11);
        fill(4, 32'hFF00_00FF, 2'b10);
        fill(6, 32'h00FF_FFFF, 2'b00);
        fill(7, 32'h5600_AA00, 2'b01);
        fetch(0, "R4 long nonzero");
        fetch(1, "R3 medium");
        fetch(2, "R3 short all gated");
        fetch(3, "R3 code 11 as long");
        fetch(4, "R4 zero lower used");
        fetch(6, "R3 short upper zero");
        fetch(7, "R4 mixed medium");
        idle(3);
        check("R2 no request no valid", W'(fetch_vld), W'(0));
        check("R7 upper hold idle", W'(upper_gated_cnt), W'(exp_up));
        check("R7 lower hold idle", W'(lower_gated_cnt), W'(exp_lo));

        step(1'b1, 0, 32'hCAFE_0000, 2'b00, 1'b1, 0, "R8 old contents same cycle");
        fetch(0, "R8 new contents");

        fill(8, 32'h9999_9999, 2'b10);
        fetch(9, "R9 neighbour unfilled");
        fetch(1, "R9 earlier entry kept");
        fetch(8, "R9 filled entry");

        for (int i = 0; i < 40; i++) fetch(2, "R6 wrap run");
        idle(2);

        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 80; i++) begin
            logic [W-1:0] w;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            w  = {lf[7:0] ^ lf[23:16], lf[15:8], lf[31:24], lf[11:4]};
            if (lf[3]) w[31:24] = '0;
            if (lf[9]) w[23:16] = '0;
            if (lf[13]) w[7:0] = '0;
            step(1'b1, int'(lf[19:16]), w, lf[21:20], lf[2] | lf[5], int'(lf[27:24]), "R4 mixed stream");
        end
        idle(3);
        check("R2 all requests answered", W'(exp_q.size()), W'(0));
        done = 1'b1;
        summary();
        $finish;
    end

endmodule